// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block tracks line-granular reservations held by a single requester and decides the outcome of every conditional store. A linked load that completes places a reservation on its cache line. A later conditional store to that line succeeds only while the reservation survives. Ordinary stores, conditional stores and coherence invalidations all remove it.

The cache controller reports each completed access on the completion port. That report carries the line address, a two-bit operation code and a flag saying whether the line is resident in the cache. The coherence side reports a lost-permission invalidation on the invalidate port. One cycle after each completion, the block returns three things: whether the operation succeeded, the one-bit result value the processor sees for a conditional store, and whether the store data may be written into the line.

The reservation store is a small table of line-address entries, each with a valid bit. A linked load that finds the table full replaces an entry in round-robin order.

Top module: `llsc_monitor`

## Requirements
- R1: A resident linked load (op code 2'b01) records a reservation for its line and reports ok=1, flag=0, commit=0.
- R2: A resident conditional store (op code 2'b10) reports ok=flag=commit=1 when its line is reserved. When the line is not reserved it reports ok=flag=commit=0, so a failed conditional store never commits.
- R3: Every resident conditional store removes the reservation on its line, whether it succeeds or fails.
- R4: A resident ordinary store (op code 2'b11) removes the reservation on its line and reports ok=1, flag=0, commit=1. A read (op code 2'b00) reports ok=1, flag=0, commit=0 and leaves reservations unchanged.
- R5: When the line is not resident, the operation is reported as successful and the table is left untouched. A conditional store then reports ok=flag=commit=1, a store reports ok=1, flag=0, commit=1, and a linked load or read reports ok=1, flag=0, commit=0.
- R6: An invalidation removes the reservation on its own line only.
- R7: When an invalidation and a completion name the same line in the same cycle, the invalidation wins. A conditional store then fails, and a linked load leaves no reservation.
- R8: The table holds ENTRIES distinct lines. A linked load to a line already reserved uses no new entry. A linked load to a full table replaces entries in round-robin order starting at entry 0, and free entries are filled lowest index first.
- R9: Results are registered. res_valid is high exactly one cycle after a completion and never in the cycle after a reset cycle. While res_valid is low, ok, flag and commit are 0. Reset clears every reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | A completed access is reported this cycle |
| cmp_op | input | 2 | Operation: 00 read, 01 linked load, 10 conditional store, 11 store |
| cmp_present | input | 1 | Addressed line is resident in the cache |
| cmp_line | input | LINE_W | Line address of the completed access |
| inv_valid | input | 1 | Loss-of-permission invalidation this cycle |
| inv_line | input | LINE_W | Line address being invalidated |
| res_valid | output | 1 | Result of last cycle's completion is valid |
| res_ok | output | 1 | Operation succeeded |
| res_flag | output | 1 | Conditional store result value (1 success, 0 failure) |
| res_commit | output | 1 | Store data may be written into the line |

## Verification
On every cycle the assertions check four things: no two table entries hold the same line, a line is no longer reserved after a clearing store or an invalidation, a recorded linked load is visible on the following cycle, and a failed result never carries a commit or a set flag. They also check that a result follows each completion and that outputs stay quiet when no result is valid. Only the bench's scenarios can show the behaviour that depends on history. That covers which line the round-robin replacement evicts, the invalidate-wins rule on a same-line collision, and the fact that reads, non-resident accesses and invalidations of other lines leave a reservation usable.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_LINK  = 2'b01,
    OP_COND  = 2'b10,
    OP_STORE = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
  input  logic [LINE_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = valid[g] && (lines[g] == key);
  end
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             replace,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (replace) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign victim = ptr_q;

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= IDX_W'(ENTRIES - 1));
endmodule

// File: rtl/llsc_table.sv
module llsc_table
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  llsc_op_e          cmp_op,
  input  logic              cmp_present,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              reserved
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [ENTRIES-1:0]             hit_cmp, hit_inv_raw, hit_inv, alive, valid_d;
  logic                           clash, act, do_clear, do_alloc, full;
  logic [IDX_W-1:0]               free_idx, victim, slot;

  llsc_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_cmp_match (
    .valid(valid_q), .lines(line_q), .key(cmp_line), .hit(hit_cmp));
  llsc_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_inv_match (
    .valid(valid_q), .lines(line_q), .key(inv_line), .hit(hit_inv_raw));

  // Invalidation is applied before the completion looks at the table.
  assign hit_inv  = inv_valid ? hit_inv_raw : '0;
  assign alive    = valid_q & ~hit_inv;
  assign reserved = |(hit_cmp & alive);
  assign clash    = inv_valid && (inv_line == cmp_line);
  assign act      = cmp_valid && cmp_present;
  assign do_clear = act && (cmp_op == OP_COND || cmp_op == OP_STORE);
  assign do_alloc = act && (cmp_op == OP_LINK) && !clash && !reserved;
  assign full     = &alive;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!alive[i]) free_idx = IDX_W'(i);
    end
  end

  llsc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .replace(do_alloc && full), .victim(victim));

  assign slot = full ? victim : free_idx;

  always_comb begin
    valid_d = alive & ~(do_clear ? hit_cmp : '0);
    if (do_alloc) valid_d[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // Line addresses carry no reset, keeping the array RAM-friendly.
  always_ff @(posedge clk) begin
    if (do_alloc) line_q[slot] <= cmp_line;
  end

  // Checker state for the assertions below.
  logic              chk_clr_q, chk_set_q, chk_inv_q;
  logic [LINE_W-1:0] chk_line_q, chk_inv_line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_clr_q <= 1'b0;
      chk_set_q <= 1'b0;
      chk_inv_q <= 1'b0;
    end else begin
      chk_clr_q <= do_clear;
      chk_set_q <= do_alloc;
      chk_inv_q <= inv_valid;
    end
    chk_line_q     <= cmp_line;
    chk_inv_line_q <= inv_line;
  end

  function automatic logic held(input logic [LINE_W-1:0] l);
    logic r = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (valid_q[i] && line_q[i] == l) r = 1'b1;
    return r;
  endfunction

  a_r8_unique_lines: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_cmp));
  a_r3_cleared_after_store: assert property (@(posedge clk) disable iff (rst)
    chk_clr_q |-> !held(chk_line_q));
  a_r6_cleared_after_inv: assert property (@(posedge clk) disable iff (rst)
    chk_inv_q |-> !held(chk_inv_line_q));
  a_r1_link_recorded: assert property (@(posedge clk) disable iff (rst)
    chk_set_q |-> held(chk_line_q));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_op,
  input  logic              cmp_present,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              res_valid,
  output logic              res_ok,
  output logic              res_flag,
  output logic              res_commit
);
  llsc_op_e op;
  logic     reserved, ok_d, flag_d, commit_d;

  assign op = llsc_op_e'(cmp_op);

  llsc_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_table (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_op(op), .cmp_present(cmp_present),
    .cmp_line(cmp_line), .inv_valid(inv_valid), .inv_line(inv_line),
    .reserved(reserved));

  always_comb begin
    ok_d = 1'b1; flag_d = 1'b0; commit_d = 1'b0;
    unique case (op)
      OP_COND: begin
        ok_d     = !cmp_present || reserved;
        flag_d   = ok_d;
        commit_d = ok_d;
      end
      OP_STORE: commit_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_ok <= 1'b0; res_flag <= 1'b0; res_commit <= 1'b0;
    end else begin
      res_valid  <= cmp_valid;
      res_ok     <= cmp_valid && ok_d;
      res_flag   <= cmp_valid && flag_d;
      res_commit <= cmp_valid && commit_d;
    end
  end

  a_r2_fail_no_commit: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ok) |-> (!res_commit && !res_flag));
  a_r2_flag_implies_ok: assert property (@(posedge clk) disable iff (rst)
    res_flag |-> res_ok);
  a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_ok && !res_flag && !res_commit));
  a_r9_one_cycle_result: assert property (@(posedge clk) disable iff (rst)
    ($past(cmp_valid) && !$past(rst)) |-> res_valid);
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 26;

  logic clk = 1'b0, rst = 1'b1;
  logic cmp_valid = 0, cmp_present = 0, inv_valid = 0;
  logic [1:0] cmp_op = 0;
  logic [LW-1:0] cmp_line = '0, inv_line = '0;
  logic res_valid, res_ok, res_flag, res_commit;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.ENTRIES(4), .LINE_W(LW)) u_llsc_monitor (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
    .cmp_present(cmp_present), .cmp_line(cmp_line), .inv_valid(inv_valid),
    .inv_line(inv_line), .res_valid(res_valid), .res_ok(res_ok),
    .res_flag(res_flag), .res_commit(res_commit));

  // {inv_v, inv_line[7:0], cmp_v, op[1:0], present, line[7:0], exp{valid,ok,flag,commit}, req[3:0]}
  localparam int NV = 39;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd1,4'b1100,4'd1},  // R1 link 1
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd1,4'b1111,4'd2},  // R2 cond success
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd1,4'b1000,4'd3},  // R3 cleared by cond
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd1,4'b1100,4'd1},  // R1
    {1'b0,8'd0,1'b1,2'd3,1'b1,8'd1,4'b1101,4'd4},  // R4 store
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd1,4'b1000,4'd4},  // R4 store broke it
    {1'b0,8'd0,1'b1,2'd2,1'b0,8'd2,4'b1111,4'd5},  // R5 absent cond
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd2,4'b1100,4'd1},  // R1
    {1'b1,8'd2,1'b0,2'd0,1'b0,8'd0,4'b0000,4'd9},  // R9 no completion
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd2,4'b1000,4'd6},  // R6 inv cleared
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd3,4'b1100,4'd1},  // R1
    {1'b1,8'd3,1'b1,2'd2,1'b1,8'd3,4'b1000,4'd7},  // R7 inv wins over cond
    {1'b1,8'd4,1'b1,2'd1,1'b1,8'd4,4'b1100,4'd7},  // R7 link under inv
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd4,4'b1000,4'd7},  // R7 no reservation left
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd5,4'b1100,4'd1},  // R1
    {1'b1,8'd6,1'b0,2'd0,1'b0,8'd0,4'b0000,4'd6},  // R6 other line
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd5,4'b1111,4'd6},  // R6 still reserved
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd7,4'b1100,4'd1},  // R1
    {1'b0,8'd0,1'b1,2'd0,1'b1,8'd7,4'b1100,4'd4},  // R4 read
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd7,4'b1111,4'd4},  // R4 read kept it
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd8,4'b1100,4'd1},  // R1
    {1'b0,8'd0,1'b1,2'd3,1'b0,8'd8,4'b1101,4'd5},  // R5 absent store
    {1'b0,8'd0,1'b1,2'd1,1'b0,8'd8,4'b1100,4'd5},  // R5 absent link
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd8,4'b1111,4'd5},  // R5 table untouched
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd10,4'b1100,4'd8}, // R8 fill
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd11,4'b1100,4'd8},
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd12,4'b1100,4'd8},
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd13,4'b1100,4'd8},
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd14,4'b1100,4'd8}, // R8 replaces entry 0
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd10,4'b1000,4'd8}, // R8 evicted
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd11,4'b1111,4'd8},
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd12,4'b1111,4'd8},
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd13,4'b1111,4'd8},
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd14,4'b1111,4'd8},
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd20,4'b1100,4'd8}, // R8 repeat link
    {1'b0,8'd0,1'b1,2'd1,1'b1,8'd20,4'b1100,4'd8},
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd20,4'b1111,4'd8},
    {1'b0,8'd0,1'b1,2'd2,1'b1,8'd20,4'b1000,4'd8},
    {1'b0,8'd0,1'b0,2'd0,1'b0,8'd0,4'b0000,4'd9}   // R9 idle
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {res_valid, res_ok, res_flag, res_commit};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,ok,flag,commit} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [7:0] il, input logic cv,
                       input logic [1:0] op, input logic pr, input logic [7:0] ln);
    inv_valid = iv; inv_line = LW'(il); cmp_valid = cv;
    cmp_op = op; cmp_present = pr; cmp_line = LW'(ln);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state, completion during reset gives no result
    drive(0, 0, 1, 2'd2, 1, 8'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", 4'b0000);
    rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0);

    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      v = VEC[k];
      drive(v[28], v[27:20], v[19], v[18:17], v[16], v[15:8]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v[3:0], k), v[7:4]);
    end

    // R9: reset clears reservations
    drive(0, 0, 1, 2'd1, 1, 8'd30);
    @(posedge clk); @(negedge clk);
    check("R1 link before reset", 4'b1100);
    drive(0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    drive(0, 0, 1, 2'd2, 1, 8'd30);
    @(posedge clk); @(negedge clk);
    check("R9 reset cleared reservation", 4'b1000);

    // R2: back-to-back link then conditional store to the same line
    drive(0, 0, 1, 2'd1, 1, 8'd40);
    @(posedge clk); @(negedge clk);
    drive(0, 0, 1, 2'd2, 1, 8'd40);
    @(posedge clk); @(negedge clk);
    check("R2 back-to-back success", 4'b1111);
    drive(0, 0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    check("R9 idle after burst", 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule